// File: doc/BRIEF.md
# Array coprocessor command controller

This controller sits between a processor and a configurable compute array and turns a short command stream into timed array operations. The processor selects an array configuration by identifier, loads two operands, and collects a single result. Configuration identifiers are looked up in a small set of resident slots. A hit takes effect at once. A miss takes a slot back from the least recently used identifier and charges a fixed reload delay.

Writing the second operand launches an operation that lasts a programmed number of cycles. A down-counter tracks the cycles still to run. The stall output holds the processor for the whole operation and for any reload. The array itself is stood in for by an accumulator. It starts from the first operand and, once per cycle, combines its value with the second operand using one of four functions chosen by the active configuration. That accumulator is the state the operation carries from cycle to cycle.

Commands that arrive while the controller is busy are dealt with by type. A result request is held and answered once the counter reaches zero. A configuration request is refused and flagged. Operand writes are dropped.

Top module: `coproc_ctl`

## Requirements
- R1: After reset, stall, cfg_hit, cfg_miss, cfg_err and rd_valid are 0 and cur_cfg is 0. A read issued straight after reset returns 0.
- R2: A configure command (cmd_op = 0) issued while idle whose identifier is resident raises cfg_hit for the one following cycle. It sets cur_cfg to the identifier and leaves stall low.
- R3: A configure command issued while idle whose identifier is not resident raises cfg_miss for the one following cycle and sets cur_cfg to the identifier. It holds stall high for exactly 16 cycles, starting in the following cycle.
- R4: Four identifiers are resident at a time. A miss evicts the identifier whose last hit or installation lies furthest back. Both hits and installations count as uses.
- R5: A write (cmd_op = 1) with cmd_slot = 0 stores cmd_data as operand A. A write with cmd_slot = 1 stores cmd_data as operand B and launches an operation of cmd_len cycles. In that case stall is high for exactly cmd_len cycles, starting in the following cycle.
- R6: The result begins as A. Each of the cmd_len cycles applies one step chosen by cur_cfg[1:0], modulo 2^DATA_W: 0 gives acc+B, 1 gives acc^B, 2 gives acc-B, 3 gives (acc rotated left by one)+B. With cmd_len = 0 the result is A and stall stays low.
- R7: A read (cmd_op = 2) issued while idle raises rd_valid for the one following cycle, with rd_data equal to the latest result.
- R8: A read issued while an operation is running is held. If it arrives in the first running cycle of an L-cycle operation, rd_valid rises L cycles after that cycle's clock edge, carrying the finished result.
- R9: A configure command issued while busy is refused. cfg_err rises for one cycle, cfg_hit and cfg_miss stay low, cur_cfg keeps its value, and the resident set is unchanged.
- R10: Writes issued while busy are ignored. Operand A is not changed and no operation is launched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | A command is presented this cycle |
| cmd_op | input | 2 | 0 configure, 1 write, 2 read, 3 no operation |
| cmd_slot | input | 1 | Write target: 0 operand A, 1 operand B and launch |
| cmd_id | input | ID_W | Configuration identifier for configure |
| cmd_data | input | DATA_W | Operand value for write |
| cmd_len | input | LEN_W | Operation length in cycles, used on launch |
| stall | output | 1 | Processor must hold: operation or reload in progress |
| cfg_hit | output | 1 | Configure accepted, identifier was resident |
| cfg_miss | output | 1 | Configure accepted, reload started |
| cfg_err | output | 1 | Configure refused because the controller was busy |
| cur_cfg | output | ID_W | Active configuration identifier |
| rd_valid | output | 1 | Result returned this cycle |
| rd_data | output | DATA_W | Returned result |

## Verification
The assertions check on every cycle that at most one configure outcome is signalled, that a miss comes with stall and a hit without it, that a refusal only follows a stalled cycle, and that a result is never returned from a stalled cycle. Only the bench scenarios can show stall lengths, result values for each function, the timing of held reads, least-recently-used eviction over a long identifier sequence, and that refused configures and dropped writes leave the resident set and operands untouched.

// File: rtl/coproc_ctl_pkg.sv
package coproc_ctl_pkg;

  typedef enum logic [1:0] {
    CMD_CONFIG = 2'd0,
    CMD_WRITE  = 2'd1,
    CMD_READ   = 2'd2,
    CMD_NONE   = 2'd3
  } cmd_op_e;

  typedef enum logic [1:0] {
    FN_ADD    = 2'd0,
    FN_XOR    = 2'd1,
    FN_SUB    = 2'd2,
    FN_ROTADD = 2'd3
  } step_fn_e;

endpackage

// File: rtl/coproc_cfg_cache.sv
module coproc_cfg_cache #(
  parameter int WAYS = 4,
  parameter int ID_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            look_en,
  input  logic [ID_W-1:0] look_id,
  output logic            hit
);
  localparam int AGE_W = $clog2(WAYS);

  logic [ID_W-1:0]  id_q    [WAYS];
  logic [AGE_W-1:0] age_q   [WAYS];
  logic [WAYS-1:0]  valid_q;
  logic [WAYS-1:0]  match;
  logic [AGE_W-1:0] hit_way;
  logic [AGE_W-1:0] victim;
  logic [AGE_W-1:0] sel_way;
  logic [AGE_W-1:0] sel_age;

  genvar g;
  generate
    for (g = 0; g < WAYS; g++) begin : g_way
      assign match[g] = valid_q[g] && (id_q[g] == look_id);
    end
  endgenerate

  always_comb begin
    hit     = 1'b0;
    hit_way = '0;
    victim  = '0;
    for (int i = 0; i < WAYS; i++) begin
      if (match[i]) begin
        hit     = 1'b1;
        hit_way = AGE_W'(i);
      end
      if (age_q[i] == AGE_W'(WAYS - 1)) victim = AGE_W'(i);
    end
    sel_way = hit ? hit_way : victim;
    sel_age = age_q[sel_way];
  end

  // Ages form a permutation; empty slots always hold the oldest ages,
  // so the oldest slot is both the fill target and the eviction target.
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      for (int i = 0; i < WAYS; i++) begin
        id_q[i]  <= '0;
        age_q[i] <= AGE_W'(WAYS - 1 - i);
      end
    end else if (look_en) begin
      for (int i = 0; i < WAYS; i++) begin
        if (AGE_W'(i) == sel_way) begin
          age_q[i]   <= '0;
          valid_q[i] <= 1'b1;
          id_q[i]    <= look_id;
        end else if (age_q[i] < sel_age) begin
          age_q[i] <= age_q[i] + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/coproc_reload_timer.sv
module coproc_reload_timer #(
  parameter int RELOAD_CYC = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic busy_next
);
  localparam int CNT_W = $clog2(RELOAD_CYC + 1);

  logic [CNT_W-1:0] cnt_q;

  assign busy      = (cnt_q != '0);
  assign busy_next = start || (cnt_q > CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst)           cnt_q <= '0;
    else if (start)    cnt_q <= CNT_W'(RELOAD_CYC);
    else if (busy)     cnt_q <= cnt_q - 1'b1;
  end

endmodule

// File: rtl/coproc_op_engine.sv
module coproc_op_engine
  import coproc_ctl_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_a,
  input  logic              launch,
  input  logic [DATA_W-1:0] wdata,
  input  logic [LEN_W-1:0]  len,
  input  logic [1:0]        fsel,
  output logic              running,
  output logic              run_next,
  output logic [DATA_W-1:0] acc
);
  logic [DATA_W-1:0] opa_q, opb_q, acc_q;
  logic [LEN_W-1:0]  cnt_q;

  function automatic logic [DATA_W-1:0] step(
    input logic [DATA_W-1:0] a, input logic [DATA_W-1:0] b, input logic [1:0] f);
    case (step_fn_e'(f))
      FN_ADD:  step = a + b;
      FN_XOR:  step = a ^ b;
      FN_SUB:  step = a - b;
      default: step = {a[DATA_W-2:0], a[DATA_W-1]} + b;
    endcase
  endfunction

  assign running  = (cnt_q != '0);
  assign run_next = launch ? (len != '0) : (cnt_q > LEN_W'(1));
  assign acc      = acc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      opa_q <= '0;
      opb_q <= '0;
      acc_q <= '0;
      cnt_q <= '0;
    end else begin
      if (load_a) opa_q <= wdata;
      if (launch) begin
        opb_q <= wdata;
        acc_q <= opa_q;
        cnt_q <= len;
      end else if (running) begin
        acc_q <= step(acc_q, opb_q, fsel);
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

endmodule

// File: rtl/coproc_ctl.sv
module coproc_ctl
  import coproc_ctl_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int ID_W       = 4,
  parameter int LEN_W      = 8,
  parameter int WAYS       = 4,
  parameter int RELOAD_CYC = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic              cmd_slot,
  input  logic [ID_W-1:0]   cmd_id,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic [LEN_W-1:0]  cmd_len,
  output logic              stall,
  output logic              cfg_hit,
  output logic              cfg_miss,
  output logic              cfg_err,
  output logic [ID_W-1:0]   cur_cfg,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  logic is_cfg, is_wr, is_rd, busy;
  logic cfg_ok, cfg_rej, load_a, launch;
  logic hit, rl_busy, rl_busy_next, eng_run, eng_run_next;
  logic [DATA_W-1:0] acc;
  logic rd_pend_q;
  logic stall_q, hit_q, miss_q, err_q, rdv_q;
  logic [ID_W-1:0]   cfg_q;
  logic [DATA_W-1:0] rdd_q;

  assign is_cfg  = cmd_valid && (cmd_op_e'(cmd_op) == CMD_CONFIG);
  assign is_wr   = cmd_valid && (cmd_op_e'(cmd_op) == CMD_WRITE);
  assign is_rd   = cmd_valid && (cmd_op_e'(cmd_op) == CMD_READ);
  assign busy    = eng_run || rl_busy;
  assign cfg_ok  = is_cfg && !busy;
  assign cfg_rej = is_cfg && busy;
  assign load_a  = is_wr && !busy && !cmd_slot;
  assign launch  = is_wr && !busy && cmd_slot;

  coproc_cfg_cache #(.WAYS(WAYS), .ID_W(ID_W)) u_cache (
    .clk(clk), .rst(rst), .look_en(cfg_ok), .look_id(cmd_id), .hit(hit)
  );

  coproc_reload_timer #(.RELOAD_CYC(RELOAD_CYC)) u_reload (
    .clk(clk), .rst(rst), .start(cfg_ok && !hit),
    .busy(rl_busy), .busy_next(rl_busy_next)
  );

  coproc_op_engine #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_engine (
    .clk(clk), .rst(rst), .load_a(load_a), .launch(launch),
    .wdata(cmd_data), .len(cmd_len), .fsel(cfg_q[1:0]),
    .running(eng_run), .run_next(eng_run_next), .acc(acc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      stall_q   <= 1'b0;
      hit_q     <= 1'b0;
      miss_q    <= 1'b0;
      err_q     <= 1'b0;
      cfg_q     <= '0;
      rd_pend_q <= 1'b0;
      rdv_q     <= 1'b0;
      rdd_q     <= '0;
    end else begin
      stall_q <= eng_run_next || rl_busy_next;
      hit_q   <= cfg_ok && hit;
      miss_q  <= cfg_ok && !hit;
      err_q   <= cfg_rej;
      if (cfg_ok) cfg_q <= cmd_id;
      rdv_q <= 1'b0;
      if (!busy && (is_rd || rd_pend_q)) begin
        rdv_q     <= 1'b1;
        rdd_q     <= acc;
        rd_pend_q <= 1'b0;
      end else if (is_rd) begin
        rd_pend_q <= 1'b1;
      end
    end
  end

  assign stall    = stall_q;
  assign cfg_hit  = hit_q;
  assign cfg_miss = miss_q;
  assign cfg_err  = err_q;
  assign cur_cfg  = cfg_q;
  assign rd_valid = rdv_q;
  assign rd_data  = rdd_q;

endmodule

// File: rtl/coproc_ctl_chk.sv
module coproc_ctl_chk (
  input logic clk,
  input logic rst,
  input logic stall,
  input logic cfg_hit,
  input logic cfg_miss,
  input logic cfg_err,
  input logic rd_valid
);

  // R2
  one_outcome_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cfg_hit, cfg_miss, cfg_err}));

  // R2
  hit_no_stall_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_hit |-> !stall);

  // R3
  miss_stalls_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_miss |-> stall);

  // R9
  refuse_when_busy_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_err |-> $past(stall));

  // R8
  result_after_idle_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> !$past(stall));

endmodule

bind coproc_ctl coproc_ctl_chk u_chk (
  .clk(clk), .rst(rst), .stall(stall), .cfg_hit(cfg_hit),
  .cfg_miss(cfg_miss), .cfg_err(cfg_err), .rd_valid(rd_valid)
);

// File: tb/coproc_ctl_test.sv
`timescale 1ns/1ps
module coproc_ctl_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = 2'd3;
  logic        cmd_slot = 1'b0;
  logic [3:0]  cmd_id = '0;
  logic [15:0] cmd_data = '0;
  logic [7:0]  cmd_len = '0;
  logic        stall, cfg_hit, cfg_miss, cfg_err, rd_valid;
  logic [3:0]  cur_cfg;
  logic [15:0] rd_data;

  int n_checks = 0;
  int n_fail   = 0;
  int mdl_id [4];
  int mdl_n  = 0;

  coproc_ctl uut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_slot(cmd_slot), .cmd_id(cmd_id), .cmd_data(cmd_data),
    .cmd_len(cmd_len), .stall(stall), .cfg_hit(cfg_hit),
    .cfg_miss(cfg_miss), .cfg_err(cfg_err), .cur_cfg(cur_cfg),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  always #2 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  task automatic issue(input int op, input int slot, input int id,
                       input int data, input int len);
    cmd_valid = 1'b1;
    cmd_op    = 2'(op);
    cmd_slot  = 1'(slot);
    cmd_id    = 4'(id);
    cmd_data  = 16'(data);
    cmd_len   = 8'(len);
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_op    = 2'd3;
  endtask

  task automatic count_stall(output int n);
    n = 0;
    while (stall && n < 1000) begin
      @(negedge clk);
      n++;
    end
  endtask

  function automatic int mdl_find(input int id);
    for (int i = 0; i < mdl_n; i++) if (mdl_id[i] == id) return i;
    return -1;
  endfunction

  task automatic mdl_use(input int id);
    int p = mdl_find(id);
    if (p < 0) begin
      p = (mdl_n < 4) ? mdl_n : 3;
      if (mdl_n < 4) mdl_n++;
    end
    for (int i = p; i > 0; i--) mdl_id[i] = mdl_id[i-1];
    mdl_id[0] = id;
  endtask

  function automatic int model_run(input int f, input int a, input int b, input int len);
    logic [15:0] acc = 16'(a);
    logic [15:0] bb  = 16'(b);
    for (int i = 0; i < len; i++) begin
      case (f)
        0: acc = acc + bb;
        1: acc = acc ^ bb;
        2: acc = acc - bb;
        default: acc = {acc[14:0], acc[15]} + bb;
      endcase
    end
    return int'(acc);
  endfunction

  task automatic do_config(input int id);
    int exp_hit = (mdl_find(id) >= 0) ? 1 : 0;
    int n;
    issue(0, 0, id, 0, 0);
    chk(exp_hit ? "R2/R4 hit flag" : "R3/R4 hit flag", int'(cfg_hit), exp_hit);
    chk("R3/R4 miss flag", int'(cfg_miss), 1 - exp_hit);
    chk("R2 R3 cur_cfg", int'(cur_cfg), id);
    count_stall(n);
    chk(exp_hit ? "R2 no stall on hit" : "R3 reload stall length", n, exp_hit ? 0 : 16);
    mdl_use(id);
  endtask

  task automatic run_op(input int a, input int b, input int len);
    int n;
    int exp = model_run(int'(cur_cfg[1:0]), a, b, len);
    issue(1, 0, 0, a, 0);
    issue(1, 1, 0, b, len);
    count_stall(n);
    chk("R5 operation stall length", n, len);
    issue(2, 0, 0, 0, 0);
    chk("R7 idle read valid", int'(rd_valid), 1);
    chk("R6 result", int'(rd_data), exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    int n;
    int exp;
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 stall", int'(stall), 0);
    chk("R1 flags", int'({cfg_hit, cfg_miss, cfg_err}), 0);
    chk("R1 cur_cfg", int'(cur_cfg), 0);
    chk("R1 rd_valid", int'(rd_valid), 0);
    issue(2, 0, 0, 0, 0);
    chk("R1 R7 read after reset", int'(rd_valid), 1);
    chk("R1 read data", int'(rd_data), 0);

    // R4 least-recently-used sweep against a recency list
    for (int k = 0; k < 28; k++) do_config((k * 3 + k / 4) % 7);

    // R6 function sweep
    for (int f = 0; f < 4; f++) begin
      do_config(f + 8);
      run_op(16'h1234 + f * 16'h0f1, 16'h0357 ^ (f << 9), 1);
      run_op(16'h8001 - f * 3, 16'h4321 + f, 3);
      run_op(16'hfff0 ^ f, 16'h00ff + f * 16'h100, 7);
      run_op(16'h5a5a + f, 16'h1111, 0);
    end

    // R8 read held during a running operation
    do_config(11);
    exp = model_run(3, 16'h2468, 16'h0f0f, 5);
    issue(1, 0, 0, 16'h2468, 0);
    issue(1, 1, 0, 16'h0f0f, 5);
    issue(2, 0, 0, 0, 0);
    chk("R8 no early result", int'(rd_valid), 0);
    n = 0;
    while (!rd_valid && n < 100) begin
      @(negedge clk);
      n++;
    end
    chk("R8 held read delay", n, 5);
    chk("R8 held read data", int'(rd_data), exp);
    chk("R8 stall low at return", int'(stall), 0);

    // R9 configure refused while busy
    do_config(12);
    issue(1, 0, 0, 16'h0100, 0);
    issue(1, 1, 0, 16'h0003, 10);
    issue(0, 0, 13, 0, 0);
    chk("R9 refusal flag", int'(cfg_err), 1);
    chk("R9 no hit or miss", int'({cfg_hit, cfg_miss}), 0);
    chk("R9 cur_cfg kept", int'(cur_cfg), 12);
    count_stall(n);
    chk("R9 resident set unchanged", mdl_find(13) >= 0 ? 1 : 0, 0);
    do_config(13);
    issue(2, 0, 0, 0, 0);
    chk("R9 operation result intact", int'(rd_data), model_run(0, 16'h0100, 16'h0003, 10));

    // R10 writes while busy are ignored
    do_config(9);
    issue(1, 0, 0, 16'h00aa, 0);
    issue(1, 1, 0, 16'h0c0c, 6);
    issue(1, 0, 0, 16'h7777, 0);
    issue(1, 1, 0, 16'h3333, 9);
    count_stall(n);
    chk("R10 no relaunch", n, 4);
    issue(2, 0, 0, 0, 0);
    chk("R10 first result", int'(rd_data), model_run(1, 16'h00aa, 16'h0c0c, 6));
    issue(1, 1, 0, 16'h0101, 2);
    count_stall(n);
    issue(2, 0, 0, 0, 0);
    chk("R10 operand A kept", int'(rd_data), model_run(1, 16'h00aa, 16'h0101, 2));

    summary();
    $finish;
  end

endmodule